// File: doc/BRIEF.md
# Save-Area Frame Page Walker

This block finds the state-save frame that a thread will use on its next entry into a protected region, and vets every 4 KB page that frame occupies. Once started, it works out the frame's linear address from the save-area offset, the region base, the frame size in pages and the thread's current slot index. It then steps page by page across the extended-state portion of the frame. For each page it issues one metadata lookup and checks the reply: the page must be in protected memory, present and in a usable state, mapped at the expected address, of the regular type, owned by the same region as the thread's control record, and both readable and writable.

The physical page address returned for each page that passes is kept in an ordered list. After the last extended-state page, the walker computes the register-save area at the top of the frame and puts it through the same page checks. In 32-bit mode it also confirms that the last byte of that area lies inside the data segment. The walk stops at the first failure. At the end, the block pulses done together with a fault code and the address that caused the fault.

Lookups use a request/response pair of valid/ready handshakes. A request holds its valid and its address until ready is seen. The block asserts response-ready only while it is waiting for the reply to its single outstanding request, and it reads the response fields only in a cycle where both response-valid and response-ready are high. The responder may stall either channel for any number of cycles.

Top module: `save_frame_walker`

## Requirements
- R1: During and after reset, busy, done, req_valid and rsp_ready are low, and fault, fault_addr, page_count, page_pa_list and gpr_pa are all zero.
- R2: The first lookup address equals area_off + region_base + 4096 × frame_pages × slot_idx, taken modulo 2^ADDR_W.
- R3: For an extended-state size S, the block looks up ceil(S/4096) pages in ascending order, each 4096 above the one before. When S is 0 it looks up no frame pages.
- R4: req_valid and req_addr stay unchanged until req_ready is seen. No new request is raised while a reply is still owed. rsp_ready is high only while the block waits for the reply to the request it has issued.
- R5: A page fails when in_prot=0, pg_valid=0, blocked=1, pending=1, modified=1, regular=0, read=0, write=0, or when bits [ADDR_W-1:12] of the stored address differ from those of the lookup address. A failure ends the walk with fault=1 and fault_addr equal to that lookup address, and no further lookup is made.
- R6: A page whose owner identifier differs from owner_id fails in the same way as in R5.
- R7: The physical address of the k-th passing frame page (k from 0) appears in page_pa_list bits [k×PA_W +: PA_W] with its low 12 bits forced to zero. page_count gives the number of entries, and entries that were not written read as zero.
- R8: If ceil(S/4096) exceeds MAX_PAGES, the block makes no lookup and ends with fault=2 and fault_addr equal to the frame address.
- R9: After the frame pages, the block looks up the register area at frame + 4096 × frame_pages − GPR_BYTES. A failure there ends the walk with fault=1 at that address.
- R10: When the register area passes, gpr_pa holds the high bits [PA_W-1:12] of the returned physical address joined with bits [11:0] of the register-area address.
- R11: With compat32=1, a register area that passes its page checks but whose last byte (address + GPR_BYTES − 1, with carry) is above seg_limit ends with fault=2 at the register-area address. A page failure on that same reply takes precedence. With compat32=0 no limit check is made.
- R12: done is a one-cycle pulse. The fault codes are 0 for none, 1 for a page fault and 2 for a protection fault. busy is high from the cycle after an accepted start up to and including done. start is ignored while busy. The result outputs hold until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken when not busy) |
| busy | output | 1 | Walk in progress |
| area_off | input | ADDR_W | Save-area offset from the region base |
| region_base | input | ADDR_W | Region base address |
| frame_pages | input | FP_W | Frame size in pages |
| slot_idx | input | SLOT_W | Current frame slot index |
| xstate_bytes | input | XS_W | Extended-state size in bytes |
| owner_id | input | ID_W | Region identifier of the control-record page |
| compat32 | input | 1 | 1 = 32-bit mode, enables the segment limit check |
| seg_limit | input | ADDR_W | Data segment limit |
| req_valid | output | 1 | Lookup request valid |
| req_ready | input | 1 | Lookup request accepted |
| req_addr | output | ADDR_W | Linear address to look up |
| rsp_valid | input | 1 | Lookup reply valid |
| rsp_ready | output | 1 | Block waiting for a reply |
| rsp_in_prot | input | 1 | Page resolves to protected memory |
| rsp_pg_valid | input | 1 | Metadata entry valid |
| rsp_blocked | input | 1 | Page blocked |
| rsp_pending | input | 1 | Page pending |
| rsp_modified | input | 1 | Page modified |
| rsp_stored_addr | input | ADDR_W | Linear address recorded in metadata |
| rsp_regular | input | 1 | Page type is regular |
| rsp_owner | input | ID_W | Owning region identifier |
| rsp_read | input | 1 | Read permitted |
| rsp_write | input | 1 | Write permitted |
| rsp_pa | input | PA_W | Physical address of the page |
| done | output | 1 | Walk finished (one-cycle pulse) |
| fault | output | 2 | Result code |
| fault_addr | output | ADDR_W | Address that caused the fault |
| page_count | output | CNT_W | Number of recorded page addresses |
| page_pa_list | output | MAX_PAGES×PA_W | Recorded page physical addresses |
| gpr_pa | output | PA_W | Register-area physical address |

## Verification
Two things can be decided by the same reply: the page check on the register-area lookup and the 32-bit segment limit check. The bench produces this by marking the register-area page as bad while also setting seg_limit one byte below the area's last byte in 32-bit mode. The expected result is a page fault at the register-area address, not a protection fault. The bench also runs each check by itself (a bad page with the limit met, and a clean page with the limit one short or exactly met), so that an inverted precedence or an off-by-one in the limit comparison gives a visibly different fault code.

// File: rtl/sfw_pkg.sv
package sfw_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_PAGE = 2'd1,
    FLT_GP   = 2'd2
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CALC,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } walk_state_e;

endpackage

// File: rtl/sfw_addr_calc.sv
module sfw_addr_calc #(
  parameter int ADDR_W    = 32,
  parameter int FP_W      = 8,
  parameter int SLOT_W    = 8,
  parameter int XS_W      = 16,
  parameter int NP_W      = 5,
  parameter int GPR_BYTES = 184
) (
  input  logic [ADDR_W-1:0] area_off,
  input  logic [ADDR_W-1:0] region_base,
  input  logic [FP_W-1:0]   frame_pages,
  input  logic [SLOT_W-1:0] slot,
  input  logic [XS_W-1:0]   xstate_bytes,
  input  logic              compat32,
  input  logic [ADDR_W-1:0] seg_limit,
  output logic [ADDR_W-1:0] frame_addr,
  output logic [ADDR_W-1:0] gpr_addr,
  output logic [NP_W-1:0]   n_pages,
  output logic              gpr_over_limit
);
  localparam int SPAN_W = FP_W + SLOT_W;

  logic [SPAN_W-1:0] slot_span;
  logic [XS_W:0]     rounded;
  logic [ADDR_W:0]   gpr_last;

  // slot index times pages per frame gives the frame's page offset
  assign slot_span  = SPAN_W'(slot) * SPAN_W'(frame_pages);
  assign frame_addr = area_off + region_base + (ADDR_W'(slot_span) << 12);
  assign gpr_addr   = frame_addr + (ADDR_W'(frame_pages) << 12) - ADDR_W'(GPR_BYTES);

  // round the extended-state size up to whole pages
  assign rounded = {1'b0, xstate_bytes} + (XS_W+1)'(4095);
  assign n_pages = NP_W'(rounded >> 12);

  // last byte of the register area, carry kept so a wrap counts as outside
  assign gpr_last       = {1'b0, gpr_addr} + (ADDR_W+1)'(GPR_BYTES - 1);
  assign gpr_over_limit = compat32 && (gpr_last > {1'b0, seg_limit});
endmodule

// File: rtl/sfw_page_check.sv
module sfw_page_check #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 8
) (
  input  logic [ADDR_W-1:0] probe_addr,
  input  logic [ID_W-1:0]   region_id,
  input  logic              in_prot,
  input  logic              pg_valid,
  input  logic              blocked,
  input  logic              pending,
  input  logic              modified,
  input  logic [ADDR_W-1:0] stored_addr,
  input  logic              regular,
  input  logic [ID_W-1:0]   pg_owner,
  input  logic              can_read,
  input  logic              can_write,
  output logic              page_ok
);
  logic [ADDR_W-1:0] addr_diff;
  logic              same_page;
  logic              state_ok;

  assign addr_diff = stored_addr ^ probe_addr;
  assign same_page = (addr_diff >> 12) == '0;
  assign state_ok  = pg_valid && !blocked && !pending && !modified;
  assign page_ok   = in_prot && state_ok && same_page && regular &&
                     (pg_owner == region_id) && can_read && can_write;
endmodule

// File: rtl/sfw_pa_list.sv
module sfw_pa_list #(
  parameter int MAX_PAGES = 8,
  parameter int PA_W      = 32,
  parameter int CNT_W     = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      push,
  input  logic [PA_W-1:0]           push_pa,
  output logic [MAX_PAGES*PA_W-1:0] pa_flat,
  output logic [CNT_W-1:0]          count
);
  localparam logic [PA_W-1:0] PAGE_MASK = ~PA_W'(12'hFFF);

  logic [PA_W-1:0] page_only;
  assign page_only = push_pa & PAGE_MASK;

  for (genvar i = 0; i < MAX_PAGES; i++) begin : g_slot
    logic [PA_W-1:0] pa_q;
    always_ff @(posedge clk) begin
      if (!rst_n || clear)                      pa_q <= '0;
      else if (push && count == CNT_W'(i))      pa_q <= page_only;
    end
    assign pa_flat[i*PA_W +: PA_W] = pa_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear)                                  count <= '0;
    else if (push && int'(count) < MAX_PAGES)             count <= count + 1'b1;
  end
endmodule

// File: rtl/save_frame_walker.sv
module save_frame_walker
  import sfw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PA_W      = 32,
  parameter int FP_W      = 8,
  parameter int SLOT_W    = 8,
  parameter int XS_W      = 16,
  parameter int ID_W      = 8,
  parameter int MAX_PAGES = 8,
  parameter int GPR_BYTES = 184
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  output logic                      busy,
  input  logic [ADDR_W-1:0]         area_off,
  input  logic [ADDR_W-1:0]         region_base,
  input  logic [FP_W-1:0]           frame_pages,
  input  logic [SLOT_W-1:0]         slot_idx,
  input  logic [XS_W-1:0]           xstate_bytes,
  input  logic [ID_W-1:0]           owner_id,
  input  logic                      compat32,
  input  logic [ADDR_W-1:0]         seg_limit,
  output logic                      req_valid,
  input  logic                      req_ready,
  output logic [ADDR_W-1:0]         req_addr,
  input  logic                      rsp_valid,
  output logic                      rsp_ready,
  input  logic                      rsp_in_prot,
  input  logic                      rsp_pg_valid,
  input  logic                      rsp_blocked,
  input  logic                      rsp_pending,
  input  logic                      rsp_modified,
  input  logic [ADDR_W-1:0]         rsp_stored_addr,
  input  logic                      rsp_regular,
  input  logic [ID_W-1:0]           rsp_owner,
  input  logic                      rsp_read,
  input  logic                      rsp_write,
  input  logic [PA_W-1:0]           rsp_pa,
  output logic                      done,
  output logic [1:0]                fault,
  output logic [ADDR_W-1:0]         fault_addr,
  output logic [$clog2(MAX_PAGES+1)-1:0] page_count,
  output logic [MAX_PAGES*PA_W-1:0] page_pa_list,
  output logic [PA_W-1:0]           gpr_pa
);
  localparam int NP_W  = XS_W - 11;
  localparam int CNT_W = $clog2(MAX_PAGES + 1);
  localparam logic [ADDR_W-1:0] PAGE_STEP = ADDR_W'(4096);

  walk_state_e       st_q;
  fault_e            fault_q;
  logic [ADDR_W-1:0] off_q, base_q, lim_q, cur_q, faddr_q;
  logic [FP_W-1:0]   fp_q;
  logic [SLOT_W-1:0] slot_q;
  logic [XS_W-1:0]   xs_q;
  logic [ID_W-1:0]   own_q;
  logic              c32_q;
  logic [NP_W-1:0]   left_q;
  logic              on_gpr_q;
  logic [PA_W-1:0]   gpr_pa_q;

  logic [ADDR_W-1:0] frame_addr, gpr_addr;
  logic [NP_W-1:0]   n_pages;
  logic              over_limit, page_ok, too_many;
  logic              list_clear, list_push;

  sfw_addr_calc #(
    .ADDR_W(ADDR_W), .FP_W(FP_W), .SLOT_W(SLOT_W), .XS_W(XS_W),
    .NP_W(NP_W), .GPR_BYTES(GPR_BYTES)
  ) u_calc (
    .area_off(off_q), .region_base(base_q), .frame_pages(fp_q), .slot(slot_q),
    .xstate_bytes(xs_q), .compat32(c32_q), .seg_limit(lim_q),
    .frame_addr(frame_addr), .gpr_addr(gpr_addr), .n_pages(n_pages),
    .gpr_over_limit(over_limit)
  );

  sfw_page_check #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_check (
    .probe_addr(cur_q), .region_id(own_q), .in_prot(rsp_in_prot),
    .pg_valid(rsp_pg_valid), .blocked(rsp_blocked), .pending(rsp_pending),
    .modified(rsp_modified), .stored_addr(rsp_stored_addr), .regular(rsp_regular),
    .pg_owner(rsp_owner), .can_read(rsp_read), .can_write(rsp_write),
    .page_ok(page_ok)
  );

  assign too_many   = int'(n_pages) > MAX_PAGES;
  assign list_clear = (st_q == ST_IDLE) && start;
  assign list_push  = (st_q == ST_WAIT) && rsp_valid && page_ok && !on_gpr_q;

  sfw_pa_list #(.MAX_PAGES(MAX_PAGES), .PA_W(PA_W), .CNT_W(CNT_W)) u_list (
    .clk(clk), .rst_n(rst_n), .clear(list_clear), .push(list_push),
    .push_pa(rsp_pa), .pa_flat(page_pa_list), .count(page_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      fault_q  <= FLT_NONE;
      faddr_q  <= '0;
      gpr_pa_q <= '0;
      off_q    <= '0;
      base_q   <= '0;
      lim_q    <= '0;
      cur_q    <= '0;
      fp_q     <= '0;
      slot_q   <= '0;
      xs_q     <= '0;
      own_q    <= '0;
      c32_q    <= 1'b0;
      left_q   <= '0;
      on_gpr_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          off_q    <= area_off;
          base_q   <= region_base;
          fp_q     <= frame_pages;
          slot_q   <= slot_idx;
          xs_q     <= xstate_bytes;
          own_q    <= owner_id;
          c32_q    <= compat32;
          lim_q    <= seg_limit;
          fault_q  <= FLT_NONE;
          faddr_q  <= '0;
          gpr_pa_q <= '0;
          st_q     <= ST_CALC;
        end
        ST_CALC: begin
          if (too_many) begin
            fault_q <= FLT_GP;
            faddr_q <= frame_addr;
            st_q    <= ST_DONE;
          end else if (n_pages == '0) begin
            cur_q    <= gpr_addr;
            on_gpr_q <= 1'b1;
            st_q     <= ST_REQ;
          end else begin
            cur_q    <= frame_addr;
            left_q   <= n_pages;
            on_gpr_q <= 1'b0;
            st_q     <= ST_REQ;
          end
        end
        ST_REQ: if (req_ready) st_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid) begin
          if (!page_ok) begin
            fault_q <= FLT_PAGE;
            faddr_q <= cur_q;
            st_q    <= ST_DONE;
          end else if (on_gpr_q) begin
            gpr_pa_q <= {rsp_pa[PA_W-1:12], cur_q[11:0]};
            if (over_limit) begin
              fault_q <= FLT_GP;
              faddr_q <= cur_q;
            end
            st_q <= ST_DONE;
          end else if (left_q == NP_W'(1)) begin
            cur_q    <= gpr_addr;
            on_gpr_q <= 1'b1;
            st_q     <= ST_REQ;
          end else begin
            cur_q  <= cur_q + PAGE_STEP;
            left_q <= left_q - 1'b1;
            st_q   <= ST_REQ;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign req_valid  = (st_q == ST_REQ);
  assign req_addr   = cur_q;
  assign rsp_ready  = (st_q == ST_WAIT);
  assign done       = (st_q == ST_DONE);
  assign fault      = fault_q;
  assign fault_addr = faddr_q;
  assign gpr_pa     = gpr_pa_q;
endmodule

// File: rtl/save_frame_walker_chk.sv
module save_frame_walker_chk #(
  parameter int ADDR_W    = 32,
  parameter int MAX_PAGES = 8,
  parameter int CNT_W     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_ready,
  input logic              done,
  input logic [1:0]        fault,
  input logic [CNT_W-1:0]  page_count
);
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));

  // R4
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> fault != 2'd3);

  // R7
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(page_count) <= MAX_PAGES);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid && !rsp_ready && !done);

  // R4
  req_leads_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_ready);
endmodule

bind save_frame_walker save_frame_walker_chk #(
  .ADDR_W(ADDR_W), .MAX_PAGES(MAX_PAGES), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .req_valid(req_valid),
  .req_ready(req_ready), .req_addr(req_addr), .rsp_ready(rsp_ready),
  .done(done), .fault(fault), .page_count(page_count)
);

// File: tb/save_frame_walker_test.sv
`timescale 1ns/1ps
module save_frame_walker_test;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] area_off = '0, region_base = '0, seg_limit = '0;
  logic [7:0]  frame_pages = '0, slot_idx = '0, owner_id = '0;
  logic [15:0] xstate_bytes = '0;
  logic        compat32 = 1'b0;
  logic        busy, req_valid, rsp_ready, done;
  logic        req_ready = 1'b0, rsp_valid = 1'b0;
  logic [31:0] req_addr, fault_addr, gpr_pa;
  logic        rsp_in_prot = 0, rsp_pg_valid = 0, rsp_blocked = 0, rsp_pending = 0;
  logic        rsp_modified = 0, rsp_regular = 0, rsp_read = 0, rsp_write = 0;
  logic [31:0] rsp_stored_addr = '0, rsp_pa = '0;
  logic [7:0]  rsp_owner = '0;
  logic [1:0]  fault;
  logic [3:0]  page_count;
  logic [255:0] page_pa_list;

  always #10 clk = ~clk;

  save_frame_walker uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .area_off(area_off), .region_base(region_base), .frame_pages(frame_pages),
    .slot_idx(slot_idx), .xstate_bytes(xstate_bytes), .owner_id(owner_id),
    .compat32(compat32), .seg_limit(seg_limit),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_in_prot(rsp_in_prot),
    .rsp_pg_valid(rsp_pg_valid), .rsp_blocked(rsp_blocked), .rsp_pending(rsp_pending),
    .rsp_modified(rsp_modified), .rsp_stored_addr(rsp_stored_addr),
    .rsp_regular(rsp_regular), .rsp_owner(rsp_owner), .rsp_read(rsp_read),
    .rsp_write(rsp_write), .rsp_pa(rsp_pa), .done(done), .fault(fault),
    .fault_addr(fault_addr), .page_count(page_count), .page_pa_list(page_pa_list),
    .gpr_pa(gpr_pa)
  );

  int    n_chk = 0, n_fail = 0, done_cnt = 0;
  bit    finished = 0;
  string cur_tag = "R1";
  int    bad_kind[int];

  logic [31:0] exp_q[$];
  logic [1:0]  exp_fault = '0;
  logic [31:0] exp_faddr = '0, exp_gpr_pa = '0;
  logic [31:0] exp_pa[8];
  int          exp_cnt = 0;
  bit          mbusy = 0, have_res = 0, first_req = 0;

  logic [31:0] s_off, s_base, s_lim, s_req;
  logic [7:0]  s_fp, s_slot, s_own, cur_owner = '0;
  logic [15:0] s_xs;
  bit          s_c32;

  task automatic cmp(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] page_pa(input logic [31:0] a);
    return {a[31:12] ^ 20'h5A3C1, 12'hABC};
  endfunction

  function automatic logic [31:0] calc_gpr(input logic [31:0] off, base,
                                           input logic [7:0] fp, slot);
    return off + base + 32'(int'(fp) * int'(slot) * 4096) + 32'(int'(fp) * 4096) - 32'd184;
  endfunction

  function automatic bit is_bad(input logic [31:0] a);
    return bad_kind.exists(int'(a[31:12]));
  endfunction

  task automatic model_start();
    logic [31:0] fr, a, g;
    int n;
    exp_q.delete();
    foreach (exp_pa[i]) exp_pa[i] = '0;
    exp_cnt = 0; exp_gpr_pa = '0; exp_faddr = '0; exp_fault = 2'd0;
    cur_owner = s_own;
    fr = s_off + s_base + 32'(int'(s_fp) * int'(s_slot) * 4096);
    n = (int'(s_xs) + 4095) / 4096;
    if (n > 8) begin exp_fault = 2'd2; exp_faddr = fr; return; end
    for (int k = 0; k < n; k++) begin
      a = fr + 32'(k * 4096);
      exp_q.push_back(a);
      if (is_bad(a)) begin exp_fault = 2'd1; exp_faddr = a; return; end
      exp_pa[k] = {page_pa(a)[31:12], 12'h000};
      exp_cnt++;
    end
    g = fr + 32'(int'(s_fp) * 4096) - 32'd184;
    exp_q.push_back(g);
    if (is_bad(g)) begin exp_fault = 2'd1; exp_faddr = g; return; end
    exp_gpr_pa = {page_pa(g)[31:12], g[11:0]};
    if (s_c32 && ({1'b0, g} + 33'd183 > {1'b0, s_lim})) begin
      exp_fault = 2'd2; exp_faddr = g;
    end
  endtask

  task automatic compare_results(input string tag);
    cmp(tag, "fault", 64'(fault), 64'(exp_fault));
    cmp(tag, "fault_addr", 64'(fault_addr), 64'(exp_faddr));
    cmp(tag, "page_count", 64'(page_count), 64'(exp_cnt));
    for (int k = 0; k < 8; k++)
      cmp(tag, $sformatf("page_pa[%0d]", k), 64'(page_pa_list[k*32 +: 32]), 64'(exp_pa[k]));
    cmp(tag, "gpr_pa", 64'(gpr_pa), 64'(exp_gpr_pa));
  endtask

  task automatic drive_rsp(input logic [31:0] a);
    int k;
    k = is_bad(a) ? bad_kind[int'(a[31:12])] : 0;
    rsp_in_prot     = (k != 1);
    rsp_pg_valid    = (k != 2);
    rsp_blocked     = (k == 3);
    rsp_pending     = (k == 4);
    rsp_modified    = (k == 5);
    rsp_stored_addr = (k == 6) ? (a ^ 32'h0000_1000) : {a[31:12], 12'h000};
    rsp_regular     = (k != 7);
    rsp_owner       = (k == 8) ? (cur_owner ^ 8'h01) : cur_owner;
    rsp_read        = (k != 9);
    rsp_write       = (k != 10);
    rsp_pa          = page_pa(a);
  endtask

  // Responder and cycle-by-cycle reference comparison
  initial begin
    int cyc = 0, dly = 0;
    bit pend = 0, f_start = 0, f_done = 0, f_req = 0, f_rsp = 0;
    logic [31:0] paddr = '0;
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (f_start) begin model_start(); mbusy = 1; have_res = 0; first_req = 1; end
      if (f_done) mbusy = 0;
      if (f_req) begin pend = 1; paddr = s_req; dly = cyc % 4; end
      if (f_rsp) rsp_valid = 1'b0;
      if (pend && !rsp_valid) begin
        if (dly == 0) begin drive_rsp(paddr); rsp_valid = 1'b1; pend = 0; end
        else dly--;
      end
      req_ready = (cyc % 3) != 2;
      cyc++;
      #1;
      cmp("R12", "busy", 64'(busy), 64'(mbusy));
      cmp("R4", "request while reply owed", 64'(req_valid && (pend || rsp_valid)), 64'(0));
      cmp("R4", "rsp_ready with no lookup", 64'(rsp_ready && !(pend || rsp_valid)), 64'(0));
      if (req_valid && req_ready) begin
        if (exp_q.size() == 0) cmp("R3", "unexpected request", 64'(req_addr), 64'(0));
        else begin
          cmp(first_req ? "R2" : "R3", "request address", 64'(req_addr), 64'(exp_q[0]));
          void'(exp_q.pop_front());
          first_req = 0;
        end
        s_req = req_addr;
      end
      f_req = req_valid && req_ready;
      f_rsp = rsp_valid && rsp_ready;
      if (done) begin
        cmp("R12", "done outside a walk", 64'(mbusy), 64'(1));
        cmp(cur_tag, "lookups missing", 64'(exp_q.size()), 64'(0));
        compare_results(cur_tag);
        have_res = 1;
        done_cnt++;
      end else if (!mbusy && have_res) begin
        compare_results("R12");
      end
      f_done = done;
      f_start = start && !mbusy;
      if (f_start) begin
        s_off = area_off; s_base = region_base; s_fp = frame_pages; s_slot = slot_idx;
        s_xs = xstate_bytes; s_own = owner_id; s_c32 = compat32; s_lim = seg_limit;
      end
    end
  end

  task automatic run_case(input string tag, input logic [31:0] off, base,
                          input logic [7:0] fp, slot, input logic [15:0] xs,
                          input bit c32, input logic [31:0] lim, input bit poke);
    int d0;
    @(negedge clk);
    d0 = done_cnt;
    cur_tag = tag;
    area_off = off; region_base = base; frame_pages = fp; slot_idx = slot;
    xstate_bytes = xs; compat32 = c32; seg_limit = lim; owner_id = 8'h3C ^ fp;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      // R12: a second start during the walk, with different inputs
      xstate_bytes = 16'hFFFF; slot_idx = 8'h77; owner_id = 8'hEE; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_cnt == d0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  localparam logic [31:0] OFF_A = 32'h0000_2000, BASE_A = 32'h4000_0000;
  localparam logic [31:0] LIM_BIG = 32'hFFFF_FFFF;

  initial begin
    logic [31:0] g;
    int kinds[10] = '{1, 2, 3, 4, 5, 6, 7, 9, 10, 8};
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    cmp("R1", "busy", 64'(busy), 0);
    cmp("R1", "done", 64'(done), 0);
    cmp("R1", "req_valid", 64'(req_valid), 0);
    cmp("R1", "rsp_ready", 64'(rsp_ready), 0);
    cmp("R1", "fault", 64'(fault), 0);
    cmp("R1", "fault_addr", 64'(fault_addr), 0);
    cmp("R1", "page_count", 64'(page_count), 0);
    cmp("R1", "page_pa_list", 64'(page_pa_list != '0), 0);
    cmp("R1", "gpr_pa", 64'(gpr_pa), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: two pages, slot 2, 3-page frame
    run_case("R2", OFF_A, BASE_A, 8'd3, 8'd2, 16'h1800, 0, LIM_BIG, 0);
    // R2: address wraps around the top of the space
    run_case("R2", 32'h0000_1000, 32'hFFFF_E000, 8'd2, 8'd1, 16'h0900, 0, LIM_BIG, 0);
    // R3: no extended state; R10 register-area physical address
    run_case("R10", OFF_A, BASE_A, 8'd1, 8'd5, 16'h0000, 0, LIM_BIG, 0);
    // R3: exactly one page
    run_case("R3", OFF_A, BASE_A, 8'd2, 8'd0, 16'h1000, 0, LIM_BIG, 0);
    // R3: one byte over a page
    run_case("R3", OFF_A, BASE_A, 8'd3, 8'd1, 16'h1001, 0, LIM_BIG, 0);
    // R7: full list of eight pages
    run_case("R7", OFF_A, BASE_A, 8'd9, 8'd1, 16'h8000, 0, LIM_BIG, 0);
    // R8: one byte too many for the list
    run_case("R8", OFF_A, BASE_A, 8'd9, 8'd1, 16'h8001, 0, LIM_BIG, 0);
    // R5 and R6: each failing field on the second frame page
    foreach (kinds[i]) begin
      bad_kind[int'(20'h40009)] = kinds[i];
      run_case(kinds[i] == 8 ? "R6" : "R5", OFF_A, BASE_A, 8'd3, 8'd2, 16'h1800, 0, LIM_BIG, 0);
      bad_kind.delete();
    end
    // R9: register-area page fails
    g = calc_gpr(OFF_A, BASE_A, 8'd3, 8'd2);
    bad_kind[int'(g[31:12])] = 4;
    run_case("R9", OFF_A, BASE_A, 8'd3, 8'd2, 16'h1800, 0, LIM_BIG, 0);
    bad_kind.delete();
    // R11: limit one byte short in 32-bit mode
    run_case("R11", OFF_A, BASE_A, 8'd3, 8'd2, 16'h1800, 1, g + 32'd182, 0);
    // R11: limit exactly at the last byte
    run_case("R11", OFF_A, BASE_A, 8'd3, 8'd2, 16'h1800, 1, g + 32'd183, 0);
    // R11: small limit ignored in 64-bit mode
    run_case("R11", OFF_A, BASE_A, 8'd3, 8'd2, 16'h1800, 0, 32'h0000_0100, 0);
    // R11: page failure and limit violation on the same reply
    bad_kind[int'(g[31:12])] = 9;
    run_case("R11", OFF_A, BASE_A, 8'd3, 8'd2, 16'h1800, 1, g + 32'd182, 0);
    bad_kind.delete();
    // R12: start while busy is ignored
    run_case("R12", OFF_A, BASE_A, 8'd4, 8'd1, 16'h2800, 0, LIM_BIG, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #3000000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R12 watchdog: actual %0h expected %0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule